// File: doc/BRIEF.md
# Round-Robin Shared-Slave AXI4 Interconnect

This block lets several AXI4 masters share one AXI4 slave. One master at a time owns the slave. While a master owns it, that master's write-address, write-data and read-address channels are steered onto the slave port. The slave's ready signals and its write-response and read-data channels are steered back to the owner only. Every other master sees its ready and response-valid inputs held low, so any request it presents simply waits.

Each master raises a request line to ask for the slave and raises a release line to give it up. Ownership lasts across whole transactions. It moves only when the owner asks to let go and has no traffic pending or in flight on any channel. The next owner is found by walking forward in circular order from the current owner and skipping masters that are not requesting. The number of masters is a parameter. With a single master the block becomes a fixed pass-through.

Top module: `axi4_share_arb`

## Requirements
- R1: While `rst_n` is low, `grant` is zero, `s_awvalid`, `s_wvalid`, `s_arvalid`, `s_bready` and `s_rready` are low, and every bit of `m_awready`, `m_wready`, `m_arready`, `m_bvalid` and `m_rvalid` is low.
- R2: When no master owns the slave and at least one `m_req` bit is high at a clock edge, `grant` shows the chosen master from the next cycle on. The search starts one position after the last owner and wraps. Out of reset, the last owner counts as master N_MST-1, so master 0 has first priority.
- R3: `grant` is zero or one-hot, with bit i meaning master i. While master i is granted, the slave-side address/data fields and valids equal master i's. With no grant, all slave-side valids, `s_bready`, `s_rready` and all slave-side fields are zero.
- R4: Only the granted master's bit of `m_awready`, `m_wready`, `m_arready`, `m_bvalid` and `m_rvalid` may be high, and it equals the matching slave signal. The B and R payload fields are copied to every master.
- R5: While the owner's `m_rel` bit is low, `grant` does not change, whatever the other masters request.
- R6: A release from the owner is taken only when the owner presents no AW, W or AR valid in that cycle. Otherwise it is deferred until this holds while `m_rel` is still high.
- R7: When a release is taken, the next master after the owner in circular order whose `m_req` is high gets the grant at that edge. The owner itself is considered last. If none requests, `grant` goes to zero.
- R8: With N_MST = 1, the single master is granted from the first edge after reset and stays granted; `m_req` and `m_rel` have no effect.
- R9: A release is also deferred while the slave is busy. The slave is busy from an accepted AW until its B response is accepted, from an accepted AR until the R beat with `s_rlast` is accepted, and from an accepted W beat without `m_wlast` until the W beat with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_req | input | N_MST | Per-master request for the slave |
| m_rel | input | N_MST | Per-master release of ownership |
| grant | output | N_MST | One-hot current owner |
| m_awid | input | N_MST*ID_W | Write address ID per master |
| m_awaddr | input | N_MST*ADDR_W | Write address per master |
| m_awlen | input | N_MST*8 | Write burst length per master |
| m_awsize | input | N_MST*3 | Write beat size per master |
| m_awburst | input | N_MST*2 | Write burst type per master |
| m_awvalid | input | N_MST | Write address valid |
| m_awready | output | N_MST | Write address ready |
| m_wdata | input | N_MST*DATA_W | Write data |
| m_wstrb | input | N_MST*DATA_W/8 | Write byte strobes |
| m_wlast | input | N_MST | Last write beat |
| m_wvalid | input | N_MST | Write data valid |
| m_wready | output | N_MST | Write data ready |
| m_bid | output | N_MST*ID_W | Write response ID (copied) |
| m_bresp | output | N_MST*2 | Write response code (copied) |
| m_bvalid | output | N_MST | Write response valid |
| m_bready | input | N_MST | Write response ready |
| m_arid | input | N_MST*ID_W | Read address ID |
| m_araddr | input | N_MST*ADDR_W | Read address |
| m_arlen | input | N_MST*8 | Read burst length |
| m_arsize | input | N_MST*3 | Read beat size |
| m_arburst | input | N_MST*2 | Read burst type |
| m_arvalid | input | N_MST | Read address valid |
| m_arready | output | N_MST | Read address ready |
| m_rid | output | N_MST*ID_W | Read data ID (copied) |
| m_rdata | output | N_MST*DATA_W | Read data (copied) |
| m_rresp | output | N_MST*2 | Read response code (copied) |
| m_rlast | output | N_MST | Last read beat (copied) |
| m_rvalid | output | N_MST | Read data valid |
| m_rready | input | N_MST | Read data ready |
| s_awid | output | ID_W | Slave write address ID |
| s_awaddr | output | ADDR_W | Slave write address |
| s_awlen | output | 8 | Slave write burst length |
| s_awsize | output | 3 | Slave write beat size |
| s_awburst | output | 2 | Slave write burst type |
| s_awvalid | output | 1 | Slave write address valid |
| s_awready | input | 1 | Slave write address ready |
| s_wdata | output | DATA_W | Slave write data |
| s_wstrb | output | DATA_W/8 | Slave write strobes |
| s_wlast | output | 1 | Slave last write beat |
| s_wvalid | output | 1 | Slave write data valid |
| s_wready | input | 1 | Slave write data ready |
| s_bid | input | ID_W | Slave write response ID |
| s_bresp | input | 2 | Slave write response code |
| s_bvalid | input | 1 | Slave write response valid |
| s_bready | output | 1 | Slave write response ready |
| s_arid | output | ID_W | Slave read address ID |
| s_araddr | output | ADDR_W | Slave read address |
| s_arlen | output | 8 | Slave read burst length |
| s_arsize | output | 3 | Slave read beat size |
| s_arburst | output | 2 | Slave read burst type |
| s_arvalid | output | 1 | Slave read address valid |
| s_arready | input | 1 | Slave read address ready |
| s_rid | input | ID_W | Slave read data ID |
| s_rdata | input | DATA_W | Slave read data |
| s_rresp | input | 2 | Slave read response code |
| s_rlast | input | 1 | Slave last read beat |
| s_rvalid | input | 1 | Slave read data valid |
| s_rready | output | 1 | Slave read data ready |

## Verification
The bench builds two copies of the block. One has three masters, a count that is not a power of two. With it the circular search must wrap past the top index, and a release with two other candidates can show skipping and circular order. The other has a single master, which reaches the fixed pass-through variant that the arbiter generate branch selects. Both copies use 8-bit addresses and data and a 3-bit outstanding counter. The stimulus keeps the outstanding work under the counter limit, so long open bursts and pending responses come up often enough to defer releases.

// File: rtl/axi4_share_arb.sv
module axi4_share_arb #(
  parameter int N_MST  = 2,
  parameter int ID_W   = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int OUT_W  = 4,
  localparam int STRB_W = DATA_W / 8,
  localparam int IDX_W  = (N_MST > 1) ? $clog2(N_MST) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_MST-1:0]          m_req,
  input  logic [N_MST-1:0]          m_rel,
  output logic [N_MST-1:0]          grant,
  input  logic [N_MST*ID_W-1:0]     m_awid,
  input  logic [N_MST*ADDR_W-1:0]   m_awaddr,
  input  logic [N_MST*8-1:0]        m_awlen,
  input  logic [N_MST*3-1:0]        m_awsize,
  input  logic [N_MST*2-1:0]        m_awburst,
  input  logic [N_MST-1:0]          m_awvalid,
  output logic [N_MST-1:0]          m_awready,
  input  logic [N_MST*DATA_W-1:0]   m_wdata,
  input  logic [N_MST*STRB_W-1:0]   m_wstrb,
  input  logic [N_MST-1:0]          m_wlast,
  input  logic [N_MST-1:0]          m_wvalid,
  output logic [N_MST-1:0]          m_wready,
  output logic [N_MST*ID_W-1:0]     m_bid,
  output logic [N_MST*2-1:0]        m_bresp,
  output logic [N_MST-1:0]          m_bvalid,
  input  logic [N_MST-1:0]          m_bready,
  input  logic [N_MST*ID_W-1:0]     m_arid,
  input  logic [N_MST*ADDR_W-1:0]   m_araddr,
  input  logic [N_MST*8-1:0]        m_arlen,
  input  logic [N_MST*3-1:0]        m_arsize,
  input  logic [N_MST*2-1:0]        m_arburst,
  input  logic [N_MST-1:0]          m_arvalid,
  output logic [N_MST-1:0]          m_arready,
  output logic [N_MST*ID_W-1:0]     m_rid,
  output logic [N_MST*DATA_W-1:0]   m_rdata,
  output logic [N_MST*2-1:0]        m_rresp,
  output logic [N_MST-1:0]          m_rlast,
  output logic [N_MST-1:0]          m_rvalid,
  input  logic [N_MST-1:0]          m_rready,
  output logic [ID_W-1:0]           s_awid,
  output logic [ADDR_W-1:0]         s_awaddr,
  output logic [7:0]                s_awlen,
  output logic [2:0]                s_awsize,
  output logic [1:0]                s_awburst,
  output logic                      s_awvalid,
  input  logic                      s_awready,
  output logic [DATA_W-1:0]         s_wdata,
  output logic [STRB_W-1:0]         s_wstrb,
  output logic                      s_wlast,
  output logic                      s_wvalid,
  input  logic                      s_wready,
  input  logic [ID_W-1:0]           s_bid,
  input  logic [1:0]                s_bresp,
  input  logic                      s_bvalid,
  output logic                      s_bready,
  output logic [ID_W-1:0]           s_arid,
  output logic [ADDR_W-1:0]         s_araddr,
  output logic [7:0]                s_arlen,
  output logic [2:0]                s_arsize,
  output logic [1:0]                s_arburst,
  output logic                      s_arvalid,
  input  logic                      s_arready,
  input  logic [ID_W-1:0]           s_rid,
  input  logic [DATA_W-1:0]         s_rdata,
  input  logic [1:0]                s_rresp,
  input  logic                      s_rlast,
  input  logic                      s_rvalid,
  output logic                      s_rready
);

  logic             owned;
  logic [IDX_W-1:0] owner;
  logic [OUT_W-1:0] wr_open, rd_open;
  logic             w_open;

  assign grant = owned ? (N_MST'(1) << owner) : '0;

  assign s_awvalid = owned & m_awvalid[owner];
  assign s_awid    = owned ? m_awid[owner*ID_W +: ID_W]       : '0;
  assign s_awaddr  = owned ? m_awaddr[owner*ADDR_W +: ADDR_W] : '0;
  assign s_awlen   = owned ? m_awlen[owner*8 +: 8]            : '0;
  assign s_awsize  = owned ? m_awsize[owner*3 +: 3]           : '0;
  assign s_awburst = owned ? m_awburst[owner*2 +: 2]          : '0;

  assign s_wvalid  = owned & m_wvalid[owner];
  assign s_wdata   = owned ? m_wdata[owner*DATA_W +: DATA_W]  : '0;
  assign s_wstrb   = owned ? m_wstrb[owner*STRB_W +: STRB_W]  : '0;
  assign s_wlast   = owned & m_wlast[owner];

  assign s_arvalid = owned & m_arvalid[owner];
  assign s_arid    = owned ? m_arid[owner*ID_W +: ID_W]       : '0;
  assign s_araddr  = owned ? m_araddr[owner*ADDR_W +: ADDR_W] : '0;
  assign s_arlen   = owned ? m_arlen[owner*8 +: 8]            : '0;
  assign s_arsize  = owned ? m_arsize[owner*3 +: 3]           : '0;
  assign s_arburst = owned ? m_arburst[owner*2 +: 2]          : '0;

  assign s_bready  = owned & m_bready[owner];
  assign s_rready  = owned & m_rready[owner];

  assign m_awready = {N_MST{s_awready}} & grant;
  assign m_wready  = {N_MST{s_wready}}  & grant;
  assign m_arready = {N_MST{s_arready}} & grant;
  assign m_bvalid  = {N_MST{s_bvalid}}  & grant;
  assign m_rvalid  = {N_MST{s_rvalid}}  & grant;
  assign m_bid     = {N_MST{s_bid}};
  assign m_bresp   = {N_MST{s_bresp}};
  assign m_rid     = {N_MST{s_rid}};
  assign m_rdata   = {N_MST{s_rdata}};
  assign m_rresp   = {N_MST{s_rresp}};
  assign m_rlast   = {N_MST{s_rlast}};

  wire aw_hs = s_awvalid & s_awready;
  wire w_hs  = s_wvalid  & s_wready;
  wire ar_hs = s_arvalid & s_arready;
  wire b_hs  = s_bvalid  & s_bready;
  wire rl_hs = s_rvalid  & s_rready & s_rlast;

  wire busy  = (wr_open != '0) | (rd_open != '0) | w_open;
  wire quiet = ~busy & ~s_awvalid & ~s_wvalid & ~s_arvalid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_open <= '0;
      rd_open <= '0;
      w_open  <= 1'b0;
    end else begin
      wr_open <= wr_open + OUT_W'(aw_hs) - OUT_W'(b_hs);
      rd_open <= rd_open + OUT_W'(ar_hs) - OUT_W'(rl_hs);
      if (w_hs) w_open <= ~s_wlast;
    end
  end

  generate
    if (N_MST == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) owned <= 1'b0;
        else        owned <= 1'b1;
      end
      assign owner = '0;
    end else begin : g_multi
      logic             pick_ok;
      logic [IDX_W-1:0] pick;

      always_comb begin
        pick_ok = 1'b0;
        pick    = owner;
        for (int k = 1; k <= N_MST; k++) begin
          if (!pick_ok && m_req[(int'(owner) + k) % N_MST]) begin
            pick_ok = 1'b1;
            pick    = IDX_W'((int'(owner) + k) % N_MST);
          end
        end
      end

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          owned <= 1'b0;
          owner <= IDX_W'(N_MST - 1);
        end else if (!owned || (m_rel[owner] && quiet)) begin
          owned <= pick_ok;
          if (pick_ok) owner <= pick;
        end
      end

      a_r2_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant != '0) && (grant != $past(grant))) |-> ((grant & $past(m_req)) != '0));
    end
  endgenerate

  a_r3_onehot_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  a_r3_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == '0) |-> !(s_awvalid | s_wvalid | s_arvalid | s_bready | s_rready));

  a_r5_hold_without_release: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant != '0) && ((grant & m_rel) == '0)) |=> $stable(grant));

  a_r9_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(grant));

endmodule

// File: tb/tb_axi4_share_arb.sv
module tb_core #(
  parameter int N    = 3,
  parameter int IW   = 2,
  parameter int AW   = 8,
  parameter int DW   = 8,
  parameter int OW   = 3,
  parameter int CYCS = 4000
) (
  input logic clk,
  input logic rst_n
);
  localparam int SW = DW / 8;
  localparam int OMAX = (1 << OW) - 2;

  logic [N-1:0] m_req, m_rel, grant;
  logic [N*IW-1:0] m_awid, m_arid, m_bid, m_rid;
  logic [N*AW-1:0] m_awaddr, m_araddr;
  logic [N*8-1:0] m_awlen, m_arlen;
  logic [N*3-1:0] m_awsize, m_arsize;
  logic [N*2-1:0] m_awburst, m_arburst, m_bresp, m_rresp;
  logic [N-1:0] m_awvalid, m_awready, m_wlast, m_wvalid, m_wready, m_bvalid, m_bready;
  logic [N-1:0] m_arvalid, m_arready, m_rlast, m_rvalid, m_rready;
  logic [N*DW-1:0] m_wdata, m_rdata;
  logic [N*SW-1:0] m_wstrb;
  logic [IW-1:0] s_awid, s_bid, s_arid, s_rid;
  logic [AW-1:0] s_awaddr, s_araddr;
  logic [7:0] s_awlen, s_arlen;
  logic [2:0] s_awsize, s_arsize;
  logic [1:0] s_awburst, s_arburst, s_bresp, s_rresp;
  logic s_awvalid, s_awready, s_wlast, s_wvalid, s_wready, s_bvalid, s_bready;
  logic s_arvalid, s_arready, s_rlast, s_rvalid, s_rready;
  logic [DW-1:0] s_wdata, s_rdata;
  logic [SW-1:0] s_wstrb;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int owned = 0, owner = N - 1, wr = 0, rd = 0, wm = 0;
  string tag;

  axi4_share_arb #(.N_MST(N), .ID_W(IW), .ADDR_W(AW), .DATA_W(DW), .OUT_W(OW)) dut (
    .clk(clk), .rst_n(rst_n), .m_req(m_req), .m_rel(m_rel), .grant(grant),
    .m_awid(m_awid), .m_awaddr(m_awaddr), .m_awlen(m_awlen), .m_awsize(m_awsize),
    .m_awburst(m_awburst), .m_awvalid(m_awvalid), .m_awready(m_awready),
    .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wlast(m_wlast), .m_wvalid(m_wvalid),
    .m_wready(m_wready), .m_bid(m_bid), .m_bresp(m_bresp), .m_bvalid(m_bvalid),
    .m_bready(m_bready), .m_arid(m_arid), .m_araddr(m_araddr), .m_arlen(m_arlen),
    .m_arsize(m_arsize), .m_arburst(m_arburst), .m_arvalid(m_arvalid),
    .m_arready(m_arready), .m_rid(m_rid), .m_rdata(m_rdata), .m_rresp(m_rresp),
    .m_rlast(m_rlast), .m_rvalid(m_rvalid), .m_rready(m_rready),
    .s_awid(s_awid), .s_awaddr(s_awaddr), .s_awlen(s_awlen), .s_awsize(s_awsize),
    .s_awburst(s_awburst), .s_awvalid(s_awvalid), .s_awready(s_awready),
    .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wlast(s_wlast), .s_wvalid(s_wvalid),
    .s_wready(s_wready), .s_bid(s_bid), .s_bresp(s_bresp), .s_bvalid(s_bvalid),
    .s_bready(s_bready), .s_arid(s_arid), .s_araddr(s_araddr), .s_arlen(s_arlen),
    .s_arsize(s_arsize), .s_arburst(s_arburst), .s_arvalid(s_arvalid),
    .s_arready(s_arready), .s_rid(s_rid), .s_rdata(s_rdata), .s_rresp(s_rresp),
    .s_rlast(s_rlast), .s_rvalid(s_rvalid), .s_rready(s_rready)
  );

  task automatic chk(input string t, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s (N=%0d) actual=%0h expected=%0h", t, N, act, exp);
    end
  endtask

  task automatic zero_inputs();
    m_req = '0; m_rel = '0;
    m_awid = '0; m_awaddr = '0; m_awlen = '0; m_awsize = '0; m_awburst = '0; m_awvalid = '0;
    m_wdata = '0; m_wstrb = '0; m_wlast = '0; m_wvalid = '0; m_bready = '0;
    m_arid = '0; m_araddr = '0; m_arlen = '0; m_arsize = '0; m_arburst = '0; m_arvalid = '0;
    m_rready = '0;
    s_awready = 0; s_wready = 0; s_arready = 0; s_bid = '0; s_bresp = '0; s_bvalid = 0;
    s_rid = '0; s_rdata = '0; s_rresp = '0; s_rlast = 0; s_rvalid = 0;
  endtask

  task automatic advance();
    bit g, aw_hs, w_hs, ar_hs, b_hs, rl_hs, qv, found;
    int o;
    g = (owned != 0); o = owner;
    aw_hs = g && m_awvalid[o] && s_awready;
    w_hs  = g && m_wvalid[o] && s_wready;
    ar_hs = g && m_arvalid[o] && s_arready;
    b_hs  = g && s_bvalid && m_bready[o];
    rl_hs = g && s_rvalid && m_rready[o] && s_rlast;
    qv = g && (m_awvalid[o] || m_wvalid[o] || m_arvalid[o]);
    if (N == 1) begin
      tag = "R8 grant";
      owned = 1; owner = 0;
    end else begin
      if (!g) tag = "R2 grant";
      else if (!m_rel[o]) tag = "R5 grant";
      else if (wr != 0 || rd != 0 || wm != 0) tag = "R9 grant";
      else if (qv) tag = "R6 grant";
      else tag = "R7 grant";
      if (!g || (m_rel[o] && wr == 0 && rd == 0 && wm == 0 && !qv)) begin
        found = 0;
        for (int k = 1; k <= N; k++) begin
          if (!found && m_req[(owner + k) % N]) begin
            found = 1;
            owner = (owner + k) % N;
          end
        end
        owned = found ? 1 : 0;
      end
    end
    wr = wr + int'(aw_hs) - int'(b_hs);
    rd = rd + int'(ar_hs) - int'(rl_hs);
    if (w_hs) wm = s_wlast ? 0 : 1;
  endtask

  task automatic drive();
    for (int i = 0; i < N; i++) begin
      m_req[i] = ($urandom % 4) != 0;
      m_rel[i] = ($urandom % 3) == 0;
      m_awvalid[i] = (wr < OMAX) && (($urandom % 4) == 0);
      m_wvalid[i] = ($urandom % 4) == 0;
      m_wlast[i] = ($urandom % 2) == 0;
      m_arvalid[i] = (rd < OMAX) && (($urandom % 4) == 0);
      m_bready[i] = ($urandom % 2) == 0;
      m_rready[i] = ($urandom % 2) == 0;
    end
    m_awid = (N*IW)'($urandom); m_awaddr = (N*AW)'($urandom); m_awlen = (N*8)'($urandom);
    m_awsize = (N*3)'($urandom); m_awburst = (N*2)'($urandom);
    m_wdata = (N*DW)'($urandom); m_wstrb = (N*SW)'($urandom);
    m_arid = (N*IW)'($urandom); m_araddr = (N*AW)'($urandom); m_arlen = (N*8)'($urandom);
    m_arsize = (N*3)'($urandom); m_arburst = (N*2)'($urandom);
    s_awready = ($urandom % 2) == 0; s_wready = ($urandom % 2) == 0;
    s_arready = ($urandom % 2) == 0;
    s_bvalid = (wr > 0) && (($urandom % 2) == 0);
    s_rvalid = (rd > 0) && (($urandom % 2) == 0);
    s_rlast = ($urandom % 3) == 0;
    s_bid = IW'($urandom); s_bresp = 2'($urandom); s_rid = IW'($urandom);
    s_rdata = DW'($urandom); s_rresp = 2'($urandom);
  endtask

  task automatic compare();
    logic [N-1:0] eg;
    logic [127:0] e;
    int o;
    o = owner;
    eg = (owned != 0) ? (N'(1) << o) : '0;
    chk(tag, 128'(grant), 128'(eg));
    e = (owned != 0) ? 128'({m_awvalid[o], m_awid[o*IW +: IW], m_awaddr[o*AW +: AW],
          m_awlen[o*8 +: 8], m_awsize[o*3 +: 3], m_awburst[o*2 +: 2]}) : '0;
    chk("R3 aw path", 128'({s_awvalid, s_awid, s_awaddr, s_awlen, s_awsize, s_awburst}), e);
    e = (owned != 0) ? 128'({m_wvalid[o], m_wdata[o*DW +: DW], m_wstrb[o*SW +: SW], m_wlast[o]}) : '0;
    chk("R3 w path", 128'({s_wvalid, s_wdata, s_wstrb, s_wlast}), e);
    e = (owned != 0) ? 128'({m_arvalid[o], m_arid[o*IW +: IW], m_araddr[o*AW +: AW],
          m_arlen[o*8 +: 8], m_arsize[o*3 +: 3], m_arburst[o*2 +: 2]}) : '0;
    chk("R3 ar path", 128'({s_arvalid, s_arid, s_araddr, s_arlen, s_arsize, s_arburst}), e);
    e = (owned != 0) ? 128'({m_bready[o], m_rready[o]}) : '0;
    chk("R3 resp ready", 128'({s_bready, s_rready}), e);
    chk("R4 readies", 128'({m_awready, m_wready, m_arready}),
        128'({eg & {N{s_awready}}, eg & {N{s_wready}}, eg & {N{s_arready}}}));
    chk("R4 resp valids", 128'({m_bvalid, m_rvalid}),
        128'({eg & {N{s_bvalid}}, eg & {N{s_rvalid}}}));
    chk("R4 payload copy", 128'({m_rdata[DW-1:0], m_bid[IW-1:0], m_rlast[0]}),
        128'({s_rdata, s_bid, s_rlast}));
  endtask

  initial begin
    zero_inputs();
    s_awready = 1; s_wready = 1; s_arready = 1; s_bvalid = 1; s_rvalid = 1;
    m_awvalid = '1; m_wvalid = '1; m_arvalid = '1; m_bready = '1; m_rready = '1;
    repeat (2) @(negedge clk);
    chk("R1 reset grant", 128'(grant), 128'(0));
    chk("R1 reset slave side", 128'({s_awvalid, s_wvalid, s_arvalid, s_bready, s_rready}), 128'(0));
    chk("R1 reset master side", 128'({m_awready, m_wready, m_arready, m_bvalid, m_rvalid}), 128'(0));
    zero_inputs();
    @(posedge rst_n);
    for (int c = 0; c < CYCS; c++) begin
      @(negedge clk);
      advance();
      drive();
      #1;
      compare();
    end
    done = 1;
  end
endmodule

module tb_axi4_share_arb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  bit timeout = 0;
  int total, bad;

  always #2 clk = ~clk;

  tb_core #(.N(3)) multi (.clk(clk), .rst_n(rst_n));
  tb_core #(.N(1)) single (.clk(clk), .rst_n(rst_n));

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    fork
      wait (multi.done && single.done);
      begin
        repeat (100000) @(posedge clk);
        timeout = 1;
      end
    join_any
    total = multi.n_chk + single.n_chk;
    bad = multi.n_bad + single.n_bad;
    if (timeout) begin
      total++;
      bad++;
      $display("FAIL R2 watchdog: actual=not finished expected=finished");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, bad);
    $finish;
  end
endmodule